// File: doc/BRIEF.md
# Eight-Channel Endpoint DMA Engine

This block moves data between system memory and the FIFOs of USB endpoints on behalf of up to eight independent channels. Software sets up a channel through a small memory-mapped register port. It loads a starting address and a byte count, then writes the channel's control word with the enable bit set. From then on the engine runs the transfer one 32-bit word at a time. Each word needs one memory handshake and one endpoint handshake. After every word the channel's address register rises and its count register falls by the number of bytes moved, so software can read progress at any time as current address minus start address.

The memory side is a word-wide request/acknowledge master. It reports the channel's burst field and has an error return. The endpoint side is a request/acknowledge handshake that carries the endpoint number and the direction. Active channels share the single engine in round-robin order, one burst per grant.

When a channel finishes, or when a memory error stops it, the engine clears the channel's enable bit and raises the channel's bit in a shared status byte. That byte clears when it is read. A single interrupt output is the OR of the status bits whose channel has interrupt enable set.

The engine is a three-state machine:
- ST_IDLE waits for a grant. A granted channel with a zero count completes at once. Any other granted channel goes to ST_FETCH.
- ST_FETCH reads one word from the source side: memory when the direction bit is 1, the endpoint when it is 0. On its acknowledge the machine goes to ST_PUT. A memory error returns it to ST_IDLE.
- ST_PUT writes that word to the other side. On its acknowledge the word is complete, and the machine then goes:
  - back to ST_FETCH while the burst and the count both have room left;
  - to ST_IDLE when the burst is used up, when the count reaches zero, on a memory error, or when the channel was aborted meanwhile.

Top module: `xdma_engine`

## Requirements
- R1: Registers sit in a window at byte offset 0x200. The status byte is at 0x200. Channel n (0..7) has its control word at 0x204+16n, its address at 0x208+16n and its count at 0x20C+16n, and each reads back what was written to it.
- R2: Bits 1:0 of a written address are dropped. The address register reads back with them zero, and the transfer starts at that aligned address.
- R3: Writing the control word with bit 0 (enable) set starts the channel. Each word moves min(4, remaining) bytes, raises the address by that amount and lowers the count by the same amount, so a finished transfer leaves count 0 and address = start + length.
- R4: Control bit 1 selects the direction. With 1, each word is read from memory and then written to the endpoint. With 0, it is read from the endpoint and then written to memory. The endpoint port carries control bits 7:4 as the endpoint number.
- R5: Control bits 10:9 set the words per grant: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 16. The field is presented on mem_burst while the channel uses memory.
- R6: After each burst the engine grants the next enabled channel in ascending circular order, so two busy channels alternate whole bursts.
- R7: Control bit 2 selects the mode. With 1, the channel runs until its count is zero. With 0, the channel ends after one burst, leaving the remaining count and advanced address.
- R8: When a channel ends, the engine clears its enable bit and sets bit n of the status byte.
- R9: A word acknowledged with mem_err sets control bit 8, clears enable and sets status bit n. The failed word does not advance address or count.
- R10: Reading the status byte returns its bits and clears them.
- R11: irq is high exactly when some status bit n is set while control bit 3 (interrupt enable) of channel n is set.
- R12: Writing zero to the control, address and count of a running channel stops it. At most the word in flight completes, and the registers keep the zeros.
- R13: A channel enabled with a count of zero ends at once with its status bit set and no memory or endpoint activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on a status read) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the strobe cycle |
| irq | output | 1 | Interrupt, OR of enabled status bits |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_burst | output | 2 | Burst field of the channel being served |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Bus error, valid with mem_ack |
| ep_req | output | 1 | Endpoint word request |
| ep_to_ep | output | 1 | 1: word goes to the endpoint; 0: word comes from it |
| ep_num | output | 4 | Endpoint number of the channel being served |
| ep_wdata | output | 32 | Data toward the endpoint |
| ep_rdata | input | 32 | Data from the endpoint, valid with ep_ack |
| ep_ack | input | 1 | Endpoint acknowledge |

## Verification
The bench targets these corner cases, and names the fault each one exposes:
- Final partial words and unaligned written addresses. A design that moved whole words or kept the low address bits would end with the wrong address or count.
- Two channels busy at once. The bench checks that endpoint traffic comes in alternating runs of exactly one burst; a broken arbiter would starve one channel or split bursts.
- A memory error in mid-transfer. It must freeze the address at the failed word and flag the error bit. The error path is run with interrupt enable clear to show that irq stays low.
- An abort in mid-transfer. Registers must stay zero afterwards instead of being overwritten by the engine.
- A zero-length start. It must complete without bus traffic.

// File: rtl/xdma_pkg.sv
package xdma_pkg;

    // Control word field positions (fixed by the register map)
    localparam int unsigned B_EN    = 0;
    localparam int unsigned B_DIR   = 1;
    localparam int unsigned B_MODE  = 2;
    localparam int unsigned B_IE    = 3;
    localparam int unsigned B_EP_LO = 4;
    localparam int unsigned B_ERR   = 8;
    localparam int unsigned B_BU_LO = 9;
    localparam int unsigned CTRL_W  = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_PUT   = 2'd2
    } eng_st_t;

    function automatic logic [4:0] burst_words(input logic [1:0] f);
        unique case (f)
            2'd0: burst_words = 5'd1;
            2'd1: burst_words = 5'd4;
            2'd2: burst_words = 5'd8;
            default: burst_words = 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/xdma_chan_regs.sv
module xdma_chan_regs
    import xdma_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic [31:0]       wdata,
    input  logic              upd,
    input  logic              set_fin,
    input  logic              set_err,
    input  logic [AW-1:0]     new_addr,
    input  logic [CW-1:0]     new_cnt,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [AW-1:0]     addr_q,
    output logic [CW-1:0]     cnt_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            addr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= wdata[CTRL_W-1:0];
            end else if (set_err) begin
                ctrl_q[B_EN]  <= 1'b0;
                ctrl_q[B_ERR] <= 1'b1;
            end else if (set_fin) begin
                ctrl_q[B_EN] <= 1'b0;
            end

            if (wr_addr)  addr_q <= {wdata[AW-1:2], 2'b00};
            else if (upd) addr_q <= new_addr;

            if (wr_cnt)   cnt_q <= wdata[CW-1:0];
            else if (upd) cnt_q <= new_cnt;
        end
    end

    AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !wr_cnt) |=> (cnt_q <= $past(cnt_q)));  // R3

endmodule

// File: rtl/xdma_rr_arb.sv
module xdma_rr_arb #(
    parameter int unsigned NCH  = 8,
    localparam int unsigned CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  req,
    input  logic            take,
    output logic [CH_W-1:0] gnt,
    output logic            gnt_valid
);

    logic [CH_W-1:0] last_q;

    always_comb begin
        gnt       = '0;
        gnt_valid = 1'b0;
        for (int i = 1; i <= int'(NCH); i++) begin
            if (!gnt_valid && req[(int'(last_q) + i) % int'(NCH)]) begin
                gnt       = CH_W'((int'(last_q) + i) % int'(NCH));
                gnt_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    last_q <= CH_W'(NCH - 1);
        else if (take) last_q <= gnt;
    end

    AST_RR_MOVES_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && req[last_q] && ($countones(req) > 1)) |-> (gnt != last_q));  // R6

endmodule

// File: rtl/xdma_xfer_fsm.sv
module xdma_xfer_fsm
    import xdma_pkg::*;
#(
    parameter int unsigned NCH = 8,
    parameter int unsigned AW  = 32,
    parameter int unsigned CW  = 24,
    localparam int unsigned CH_W = $clog2(NCH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0]           en_vec,
    input  logic [NCH-1:0]           dir_vec,
    input  logic [NCH-1:0]           mode_vec,
    input  logic [NCH-1:0][1:0]      burst_all,
    input  logic [NCH-1:0][3:0]      ep_all,
    input  logic [NCH-1:0][AW-1:0]   addr_all,
    input  logic [NCH-1:0][CW-1:0]   cnt_all,
    input  logic [CH_W-1:0]          gnt,
    input  logic                     gnt_valid,
    output logic                     take,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [AW-1:0]            mem_addr,
    output logic [1:0]               mem_burst,
    output logic [31:0]              mem_wdata,
    input  logic [31:0]              mem_rdata,
    input  logic                     mem_ack,
    input  logic                     mem_err,
    output logic                     ep_req,
    output logic                     ep_to_ep,
    output logic [3:0]               ep_num,
    output logic [31:0]              ep_wdata,
    input  logic [31:0]              ep_rdata,
    input  logic                     ep_ack,
    output logic                     ev_valid,
    output logic [CH_W-1:0]          ev_ch,
    output logic                     ev_upd,
    output logic                     ev_fin,
    output logic                     ev_err,
    output logic [AW-1:0]            new_addr,
    output logic [CW-1:0]            new_cnt
);

    eng_st_t         st_q, st_d;
    logic [CH_W-1:0] ch_q;
    logic [4:0]      beats_q;
    logic [31:0]     data_q;
    logic            beat_end, bus_err;
    logic            cur_en, cur_dir;
    logic [CW-1:0]   cur_cnt;
    logic [2:0]      nbytes;

    assign cur_en  = en_vec[ch_q];
    assign cur_dir = dir_vec[ch_q];
    assign cur_cnt = cnt_all[ch_q];
    assign nbytes  = (cur_cnt >= CW'(4)) ? 3'd4 : cur_cnt[2:0];
    assign new_cnt  = cur_cnt - CW'(nbytes);
    assign new_addr = addr_all[ch_q] + AW'(nbytes);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state and channel events
    always_comb begin
        st_d     = st_q;
        take     = 1'b0;
        ev_valid = 1'b0;
        ev_upd   = 1'b0;
        ev_fin   = 1'b0;
        ev_err   = 1'b0;
        beat_end = 1'b0;
        bus_err  = 1'b0;
        ev_ch    = (st_q == ST_IDLE) ? gnt : ch_q;
        unique case (st_q)
            ST_IDLE: begin
                if (gnt_valid) begin
                    take = 1'b1;
                    if (cnt_all[gnt] == '0) begin
                        ev_valid = 1'b1;
                        ev_fin   = 1'b1;
                    end else begin
                        st_d = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (cur_dir) begin
                    if (mem_ack) begin
                        if (mem_err) bus_err = 1'b1;
                        else         st_d = ST_PUT;
                    end
                end else if (ep_ack) begin
                    st_d = ST_PUT;
                end
            end
            ST_PUT: begin
                if (cur_dir) begin
                    if (ep_ack) beat_end = 1'b1;
                end else if (mem_ack) begin
                    if (mem_err) bus_err  = 1'b1;
                    else         beat_end = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase

        if (bus_err) begin
            st_d = ST_IDLE;
            if (cur_en) begin
                ev_valid = 1'b1;
                ev_err   = 1'b1;
            end
        end
        if (beat_end) begin
            if (!cur_en) begin
                st_d = ST_IDLE;
            end else begin
                ev_valid = 1'b1;
                ev_upd   = 1'b1;
                if (new_cnt == '0) begin
                    ev_fin = 1'b1;
                    st_d   = ST_IDLE;
                end else if (beats_q == 5'd1) begin
                    st_d = ST_IDLE;
                    if (!mode_vec[ch_q]) ev_fin = 1'b1;
                end else begin
                    st_d = ST_FETCH;
                end
            end
        end
    end

    // Channel, burst counter and word holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q    <= '0;
            beats_q <= '0;
            data_q  <= '0;
        end else begin
            if (take) begin
                ch_q    <= gnt;
                beats_q <= burst_words(burst_all[gnt]);
            end else if (beat_end && st_d == ST_FETCH) begin
                beats_q <= beats_q - 5'd1;
            end
            if (st_q == ST_FETCH && cur_dir && mem_ack)  data_q <= mem_rdata;
            if (st_q == ST_FETCH && !cur_dir && ep_ack)  data_q <= ep_rdata;
        end
    end

    // Outputs
    always_comb begin
        mem_req   = (st_q == ST_FETCH && cur_dir) || (st_q == ST_PUT && !cur_dir);
        mem_we    = (st_q == ST_PUT);
        mem_addr  = addr_all[ch_q];
        mem_burst = burst_all[ch_q];
        mem_wdata = data_q;
        ep_req    = (st_q == ST_FETCH && !cur_dir) || (st_q == ST_PUT && cur_dir);
        ep_to_ep  = cur_dir;
        ep_num    = ep_all[ch_q];
        ep_wdata  = data_q;
    end

    AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);  // R3
    AST_EP_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_req && !ep_ack) |=> ep_req);  // R4
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_err && ev_upd));  // R9

endmodule

// File: rtl/xdma_engine.sv
module xdma_engine
    import xdma_pkg::*;
#(
    parameter int unsigned NCH = 8,
    parameter int unsigned AW  = 32,
    parameter int unsigned CW  = 24,
    localparam int unsigned CH_W = $clog2(NCH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [1:0]  mem_burst,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    input  logic        mem_err,
    output logic        ep_req,
    output logic        ep_to_ep,
    output logic [3:0]  ep_num,
    output logic [31:0] ep_wdata,
    input  logic [31:0] ep_rdata,
    input  logic        ep_ack
);

    logic [NCH-1:0][CTRL_W-1:0] ctrl_all;
    logic [NCH-1:0][AW-1:0]     addr_all;
    logic [NCH-1:0][CW-1:0]     cnt_all;
    logic [NCH-1:0][1:0]        burst_all;
    logic [NCH-1:0][3:0]        ep_all;
    logic [NCH-1:0]             en_vec, dir_vec, mode_vec, ie_vec, sts_set;
    logic [NCH-1:0]             sts_q;
    logic                       in_win, sts_hit, ch_hit;
    logic [CH_W-1:0]            rch, gnt, ev_ch;
    logic                       gnt_valid, take;
    logic                       ev_valid, ev_upd, ev_fin, ev_err;
    logic [AW-1:0]              new_addr;
    logic [CW-1:0]              new_cnt;

    assign in_win  = (reg_addr[11:8] == 4'h2);
    assign sts_hit = in_win && (reg_addr[7:0] == 8'h00);
    assign ch_hit  = in_win && (int'(reg_addr[7:4]) < int'(NCH));
    assign rch     = reg_addr[4 +: CH_W];

    for (genvar g = 0; g < int'(NCH); g++) begin : g_ch
        logic sel;
        assign sel = reg_wr && ch_hit && (reg_addr[7:4] == 4'(g));
        xdma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_ctrl  (sel && reg_addr[3:0] == 4'h4),
            .wr_addr  (sel && reg_addr[3:0] == 4'h8),
            .wr_cnt   (sel && reg_addr[3:0] == 4'hC),
            .wdata    (reg_wdata),
            .upd      (ev_valid && ev_upd && ev_ch == CH_W'(g)),
            .set_fin  (ev_valid && ev_fin && ev_ch == CH_W'(g)),
            .set_err  (ev_valid && ev_err && ev_ch == CH_W'(g)),
            .new_addr (new_addr),
            .new_cnt  (new_cnt),
            .ctrl_q   (ctrl_all[g]),
            .addr_q   (addr_all[g]),
            .cnt_q    (cnt_all[g])
        );
        assign en_vec[g]    = ctrl_all[g][B_EN];
        assign dir_vec[g]   = ctrl_all[g][B_DIR];
        assign mode_vec[g]  = ctrl_all[g][B_MODE];
        assign ie_vec[g]    = ctrl_all[g][B_IE];
        assign ep_all[g]    = ctrl_all[g][B_EP_LO +: 4];
        assign burst_all[g] = ctrl_all[g][B_BU_LO +: 2];
        assign sts_set[g]   = ev_valid && (ev_fin || ev_err) && ev_ch == CH_W'(g);
    end

    xdma_rr_arb #(.NCH(NCH)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (en_vec),
        .take      (take),
        .gnt       (gnt),
        .gnt_valid (gnt_valid)
    );

    xdma_xfer_fsm #(.NCH(NCH), .AW(AW), .CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_vec    (en_vec),
        .dir_vec   (dir_vec),
        .mode_vec  (mode_vec),
        .burst_all (burst_all),
        .ep_all    (ep_all),
        .addr_all  (addr_all),
        .cnt_all   (cnt_all),
        .gnt       (gnt),
        .gnt_valid (gnt_valid),
        .take      (take),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_burst (mem_burst),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .ep_req    (ep_req),
        .ep_to_ep  (ep_to_ep),
        .ep_num    (ep_num),
        .ep_wdata  (ep_wdata),
        .ep_rdata  (ep_rdata),
        .ep_ack    (ep_ack),
        .ev_valid  (ev_valid),
        .ev_ch     (ev_ch),
        .ev_upd    (ev_upd),
        .ev_fin    (ev_fin),
        .ev_err    (ev_err),
        .new_addr  (new_addr),
        .new_cnt   (new_cnt)
    );

    // Shared status byte: cleared by a read, new events still land
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= ((reg_rd && sts_hit) ? '0 : sts_q) | sts_set;
    end

    assign irq = |(sts_q & ie_vec);

    always_comb begin
        reg_rdata = '0;
        if (sts_hit) begin
            reg_rdata = 32'(sts_q);
        end else if (ch_hit) begin
            unique case (reg_addr[3:0])
                4'h4:    reg_rdata = 32'(ctrl_all[rch]);
                4'h8:    reg_rdata = 32'(addr_all[rch]);
                4'hC:    reg_rdata = 32'(cnt_all[rch]);
                default: reg_rdata = '0;
            endcase
        end
    end

    AST_STS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && sts_hit && sts_set == '0) |=> (sts_q == '0));  // R10
    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(sts_set) != '0 || $past(reg_wr)));  // R11

endmodule

// File: tb/xdma_engine_tb.sv
module xdma_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we, mem_ack, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_burst;
    logic        ep_req, ep_to_ep, ep_ack;
    logic [3:0]  ep_num;
    logic [31:0] ep_wdata, ep_rdata;

    always #10 clk = ~clk;  // 50 MHz

    xdma_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_burst(mem_burst), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .ep_req(ep_req),
        .ep_to_ep(ep_to_ep), .ep_num(ep_num), .ep_wdata(ep_wdata),
        .ep_rdata(ep_rdata), .ep_ack(ep_ack)
    );

    // ---------------- memory and endpoint models ----------------
    logic [31:0] mem [0:1023];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    int          mwait = 0, ewait = 0;
    int          mem_n = 0, log_n = 0, ep_rd_n = 0;
    logic [31:0] ep_log  [0:4095];
    logic [3:0]  ep_lnum [0:4095];
    logic [1:0]  mem_blog[0:4095];

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
        end else begin
            mem_ack <= 1'b0; mem_err <= 1'b0;
            if (mem_req && mem_ack) begin
                mem_blog[mem_n & 4095] <= mem_burst;
                mem_n <= mem_n + 1;
            end
            if (mem_req && !mem_ack) begin
                if (mwait == 0) begin
                    mem_ack   <= 1'b1;
                    mem_rdata <= mem[mem_addr[11:2]];
                    mem_err   <= (mem_addr == err_addr);
                    if (mem_we && mem_addr != err_addr) mem[mem_addr[11:2]] <= mem_wdata;
                    mwait <= $urandom_range(0, 2);
                end else begin
                    mwait <= mwait - 1;
                end
            end
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            ep_ack <= 1'b0; ep_rdata <= '0;
        end else begin
            ep_ack <= 1'b0;
            if (ep_req && ep_ack) begin
                ep_log[log_n & 4095]  <= ep_to_ep ? ep_wdata : ep_rdata;
                ep_lnum[log_n & 4095] <= ep_num;
                log_n <= log_n + 1;
            end
            if (ep_req && !ep_ack) begin
                if (ewait == 0) begin
                    ep_ack   <= 1'b1;
                    ep_rdata <= 32'hE000_0000 | (32'(ep_num) << 16) | 32'(ep_rd_n & 16'hFFFF);
                    ep_rd_n  <= ep_rd_n + 1;
                    ewait    <= $urandom_range(0, 2);
                end else begin
                    ewait <= ewait - 1;
                end
            end
        end
    end

    // ---------------- checking helpers ----------------
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] a_ctl(input int ch); return 12'(32'h204 + 16 * ch); endfunction
    function automatic logic [11:0] a_adr(input int ch); return 12'(32'h208 + 16 * ch); endfunction
    function automatic logic [11:0] a_cnt(input int ch); return 12'(32'h20C + 16 * ch); endfunction
    localparam logic [11:0] A_STS = 12'h200;

    function automatic logic [31:0] mk_ctrl(input bit en, input bit dir, input bit mode,
                                            input bit ie, input int ep, input int burst);
        return 32'(en) | (32'(dir) << 1) | (32'(mode) << 2) | (32'(ie) << 3)
             | (32'(ep & 15) << 4) | (32'(burst & 3) << 9);
    endfunction

    function automatic int exp_words(input int len); return (len + 3) / 4; endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #2 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic wait_idle(input int ch);
        logic [31:0] c;
        for (int k = 0; k < 4000; k++) begin
            rd(a_ctl(ch), c);
            if (!c[0]) break;
        end
    endtask

    task automatic start(input int ch, input logic [31:0] adr, input int len, input logic [31:0] ctl);
        wr(a_adr(ch), adr);
        wr(a_cnt(ch), 32'(len));
        wr(a_ctl(ch), ctl);
    endtask

    // Full transfer in multi-packet mode, checked against bench expectations
    task automatic run_xfer(input int ch, input int start_w, input int len,
                            input bit dir, input int burst, input string tag);
        logic [31:0] v;
        int base;
        base = log_n;
        start(ch, 32'(start_w * 4), len, mk_ctrl(1, dir, 1, 1, ch + 2, burst));
        wait_idle(ch);
        repeat (2) @(negedge clk);
        rd(a_adr(ch), v); chk({tag, " R3 final address"}, v, 32'(start_w * 4 + len));
        rd(a_cnt(ch), v); chk({tag, " R3 final count"}, v, 32'd0);
        rd(a_ctl(ch), v); chk({tag, " R8 enable cleared"}, 32'(v[0]), 32'd0);
        chk({tag, " R3 word count"}, 32'(log_n - base), 32'(exp_words(len)));
        for (int k = 0; k < exp_words(len); k++) begin
            chk({tag, dir ? " R4 mem->ep data" : " R4 ep->mem data"},
                ep_log[(base + k) & 4095], mem[start_w + k]);
            chk({tag, " R4 endpoint number"}, 32'(ep_lnum[(base + k) & 4095]), 32'(ch + 2));
        end
        chk({tag, " R11 irq with ie set"}, 32'(irq), 32'd1);
        rd(A_STS, v); chk({tag, " R8 status bit"}, v, 32'(1) << ch);
        @(negedge clk);
        chk({tag, " R10 irq after clear"}, 32'(irq), 32'd0);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] v;
        int base, mbase, runs, runlen, bad;
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) mem[i] = 32'(i) * 32'h9E37_79B1 + 32'h1234;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk("R10 irq at reset", 32'(irq), 32'd0);
        rd(A_STS, v); chk("R10 status at reset", v, 32'd0);
        rd(a_ctl(0), v); chk("R1 ctrl at reset", v, 32'd0);

        // Register map and alignment
        wr(a_adr(3), 32'h0000_1237);
        rd(a_adr(3), v); chk("R2 low address bits dropped", v, 32'h0000_1234);
        wr(a_cnt(3), 32'd77);
        rd(a_cnt(3), v); chk("R1 count readback", v, 32'd77);
        wr(a_ctl(3), 32'h0000_06F0);
        rd(a_ctl(3), v); chk("R1 ctrl readback", v, 32'h0000_06F0);
        wr(a_ctl(3), 32'h0);

        // Directed transfers, unaligned start address, partial last word
        begin
            base = log_n;
            start(0, 32'h0000_0103, 10, mk_ctrl(1, 1, 1, 1, 9, 1));
            wait_idle(0);
            repeat (2) @(negedge clk);
            rd(a_adr(0), v); chk("R2 start aligned, R3 end address", v, 32'h0000_010A);
            rd(a_cnt(0), v); chk("R3 count zero", v, 32'd0);
            chk("R3 three words moved", 32'(log_n - base), 32'd3);
            chk("R2 first word from aligned address", ep_log[base & 4095], mem[32'h100 >> 2]);
            chk("R4 endpoint number field", 32'(ep_lnum[base & 4095]), 32'd9);
            chk("R11 irq raised", 32'(irq), 32'd1);
            rd(A_STS, v); chk("R8 status bit 0", v, 32'h1);
            rd(A_STS, v); chk("R10 status cleared by read", v, 32'h0);
        end
        run_xfer(2, 300, 23, 1'b0, 3, "directed ep->mem");

        // Round robin between two busy channels (4-word bursts)
        begin
            base = log_n;
            start(1, 32'h0000_0200, 32, mk_ctrl(1, 1, 1, 0, 1, 1));
            start(5, 32'h0000_0300, 32, mk_ctrl(1, 1, 1, 0, 5, 1));
            wait_idle(1); wait_idle(5);
            repeat (4) @(negedge clk);
            runs = 0; runlen = 0; bad = 0;
            for (int k = 0; k < log_n - base; k++) begin
                runlen++;
                if (k == log_n - base - 1 || ep_lnum[(base + k + 1) & 4095] != ep_lnum[(base + k) & 4095]) begin
                    runs++;
                    if (runlen != 4) bad++;
                    runlen = 0;
                end
            end
            chk("R6 alternating bursts run count", 32'(runs), 32'd4);
            chk("R6 R5 every run is one 4-word burst", 32'(bad), 32'd0);
            rd(A_STS, v); chk("R8 both channels flagged", v, 32'h22);
        end

        // Single-packet mode with 8-word bursts
        begin
            mbase = mem_n;
            start(3, 32'h0000_0500, 64, mk_ctrl(1, 1, 0, 1, 3, 2));
            wait_idle(3);
            repeat (2) @(negedge clk);
            rd(a_cnt(3), v); chk("R7 single burst leaves count", v, 32'd32);
            rd(a_adr(3), v); chk("R7 single burst advances address", v, 32'h0000_0520);
            chk("R5 eight memory words", 32'(mem_n - mbase), 32'd8);
            chk("R5 burst field on mem_burst", 32'(mem_blog[mbase & 4095]), 32'd2);
            rd(A_STS, v); chk("R7 status after single burst", v, 32'h8);
        end

        // Bus error on the third word, interrupt enable clear
        begin
            base = log_n;
            err_addr = 32'h0000_0408;
            start(4, 32'h0000_0400, 32, mk_ctrl(1, 1, 1, 0, 4, 3));
            wait_idle(4);
            repeat (2) @(negedge clk);
            err_addr = 32'hFFFF_FFFF;
            rd(a_adr(4), v); chk("R9 address stops at failed word", v, 32'h0000_0408);
            rd(a_cnt(4), v); chk("R9 count not lowered for failed word", v, 32'd24);
            rd(a_ctl(4), v); chk("R9 error bit set, enable clear", v & 32'h101, 32'h100);
            chk("R9 two words delivered", 32'(log_n - base), 32'd2);
            chk("R11 irq low without ie", 32'(irq), 32'd0);
            rd(A_STS, v); chk("R9 status bit 4", v, 32'h10);
        end

        // Abort in mid-transfer
        begin
            start(6, 32'h0000_0800, 400, mk_ctrl(1, 0, 1, 1, 6, 3));
            repeat (60) @(negedge clk);
            wr(a_ctl(6), 32'h0);
            wr(a_adr(6), 32'h0);
            wr(a_cnt(6), 32'h0);
            base = log_n;
            repeat (100) @(negedge clk);
            chk("R12 at most one word after abort", 32'(log_n - base <= 1), 32'd1);
            rd(a_adr(6), v); chk("R12 address stays zero", v, 32'd0);
            rd(a_cnt(6), v); chk("R12 count stays zero", v, 32'd0);
            rd(a_ctl(6), v); chk("R12 control stays zero", v, 32'd0);
            rd(A_STS, v);
        end

        // Zero-length start
        begin
            base = log_n; mbase = mem_n;
            start(7, 32'h0000_0100, 0, mk_ctrl(1, 1, 1, 1, 7, 0));
            repeat (6) @(negedge clk);
            chk("R13 no endpoint traffic", 32'(log_n - base), 32'd0);
            chk("R13 no memory traffic", 32'(mem_n - mbase), 32'd0);
            chk("R13 irq raised", 32'(irq), 32'd1);
            rd(A_STS, v); chk("R13 status bit 7", v, 32'h80);
        end

        // Constrained random transfers
        for (int t = 0; t < 8; t++) begin
            run_xfer(int'($urandom_range(0, 7)), int'($urandom_range(0, 700)),
                     int'($urandom_range(1, 60)), 1'($urandom_range(0, 1)),
                     int'($urandom_range(0, 3)), "random");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule